// File: doc/BRIEF.md
# Queued Serial Transmitter with Half-Queue Status

This block turns 9-bit words into asynchronous serial frames on a single output line. It spares the host from feeding every character: the host loads up to sixteen words into an on-chip ring and the block sends them one after another. A mode input chooses between this queued operation and a plain one-word holding register. In the one-word mode the host writes a word and waits for the transmit-empty flag before it writes the next.

The bit period is set by a divisor input. Every bit lasts 32 times the divisor, in system clocks. A frame is a low start bit, then data least significant bit first, then an optional parity bit and a high stop bit. The whole frame is either 10 or 11 bits long. When parity is on, it takes the slot of the last data bit. In queued mode the block reports the ring position being sent and the number of words still to go. It keeps one empty flag for each half of the ring, and each flag can drive its own interrupt line. A sticky flag records any word that was refused because the ring was full.

Words enter through a valid/ready port. A word is taken on a clock edge where `wr_valid` and `wr_ready` are both high. In one-word mode, `wr_ready` is low while the holding register is occupied, and the source must hold its word. In queued mode, `wr_ready` is low while sixteen words are pending. A word offered while `wr_ready` is low in queued mode is dropped and noted, not stalled.

Top module: `qser_tx`

## Requirements
- R1: Each frame bit lasts exactly 32 x `cfg_div` clock cycles. While `cfg_div` is 0 no frame starts, and `txd` stays at 1 whatever is waiting.
- R2: A frame is a start bit of 0, then the data bits least significant bit first, then a stop bit of 1. `cfg_long`=0 gives a 10-bit frame and `cfg_long`=1 gives an 11-bit frame. With parity off, these carry 8 and 9 data bits.
- R3: With `cfg_par_en`=1 the parity bit replaces the last data bit: 7 data bits plus parity in a 10-bit frame, 8 plus parity in an 11-bit frame. With `cfg_par_odd`=0 the data bits sent and the parity bit together hold an even number of ones; with `cfg_par_odd`=1, an odd number.
- R4: In one-word mode (`cfg_queue_en`=0), `wr_ready` equals `tx_empty`. An accepted word clears `tx_empty`, and `tx_empty` returns to 1 on the edge where that word's start bit begins on `txd`.
- R5: In queued mode, up to 16 words are accepted and sent in the order they were written. `wr_ready` is 0 while 16 are pending.
- R6: `q_pending` rises by one per accepted queued word and falls by one on the edge where a queued frame's stop bit begins. When it reaches 0, sending stops and `txd` stays at 1.
- R7: `q_ptr` names the ring entry being sent or next to send. It advances by one, wrapping from 15 to 0, at each queued stop bit.
- R8: `q_bot_empty` (entries 0 to 7) and `q_top_empty` (entries 8 to 15) are both 1 after reset. A half's flag sets at the stop bit of the frame taken from its last entry (7 or 15). It clears when a word is written into that half.
- R9: `irq_bot` is `q_bot_empty` AND `cfg_irq_bot_en`; `irq_top` is `q_top_empty` AND `cfg_irq_top_en`.
- R10: In queued mode, a word offered while 16 are pending is dropped: `q_pending` and the ring are unchanged, and `q_overflow` sets. `q_overflow` stays set until `cfg_queue_en` is 0, which clears it.
- R11: After reset, `txd`=1, `tx_empty`=1, `q_pending`=0, `q_ptr`=0 and `q_overflow`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | DIV_W | Bit period divisor; 0 halts the bit clock |
| cfg_long | input | 1 | 1 selects an 11-bit frame, 0 a 10-bit frame |
| cfg_par_en | input | 1 | Send a parity bit in place of the last data bit |
| cfg_par_odd | input | 1 | 1 odd parity, 0 even parity |
| cfg_queue_en | input | 1 | 1 queued mode, 0 one-word mode |
| cfg_irq_bot_en | input | 1 | Interrupt enable for the low-half empty flag |
| cfg_irq_top_en | input | 1 | Interrupt enable for the high-half empty flag |
| wr_valid | input | 1 | Word offered on `wr_data` |
| wr_ready | output | 1 | Block can take a word this cycle |
| wr_data | input | 9 | Word to send |
| txd | output | 1 | Serial line, idle high |
| tx_empty | output | 1 | One-word holding register is free |
| q_ptr | output | log2(QDEPTH) | Ring entry being sent or next |
| q_pending | output | log2(QDEPTH)+1 | Queued words not yet at their stop bit |
| q_bot_empty | output | 1 | Low half of the ring has drained |
| q_top_empty | output | 1 | High half of the ring has drained |
| q_overflow | output | 1 | Sticky: a queued word was refused |
| irq_bot | output | 1 | Low-half interrupt |
| irq_top | output | 1 | High-half interrupt |

## Verification
The bench keeps the ring at its default depth of 16. This puts the half boundaries at entries 7 and 15, and lets a full run of sixteen frames wrap the pointer back to 0, so a later partial load starts again in the low half. The divisor is narrowed to 4 bits, and the bench uses divisors 1 and 2, which gives 32- and 64-cycle bits and keeps a sixteen-frame run short. Before each queued burst the bench loads the ring with the divisor at 0. This lets the full, overflow and flag states be observed before any frame leaves.

// File: rtl/qser_pkg.sv
package qser_pkg;

  localparam int unsigned WORD_W  = 9;
  localparam int unsigned FRAME_W = 11;

  typedef enum logic {
    FR_IDLE = 1'b0,
    FR_SEND = 1'b1
  } fr_state_t;

  // Assemble a frame, bit 0 goes out first. Unused high positions stay 1
  // so that the stop bit and trailing idle level come for free.
  function automatic logic [FRAME_W-1:0] build_frame(
    input logic [WORD_W-1:0] w,
    input logic              long_fr,
    input logic              par_en,
    input logic              par_odd
  );
    logic [FRAME_W-1:0] f;
    logic               p;
    int                 nd;
    f    = '1;
    f[0] = 1'b0;
    p    = par_odd;
    nd   = (long_fr ? 9 : 8) - (par_en ? 1 : 0);
    for (int i = 0; i < int'(WORD_W); i++) begin
      if (i < nd) begin
        f[i+1] = w[i];
        p      = p ^ w[i];
      end
    end
    if (par_en) f[nd+1] = p;
    return f;
  endfunction

endpackage

// File: rtl/qser_baud.sv
module qser_baud #(
  parameter int unsigned DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             restart,
  output logic             tick
);
  localparam int unsigned CW = DIV_W + 5;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;
  logic          run;

  assign run   = (div != '0);
  assign limit = {div, 5'd0} - CW'(1);
  assign tick  = run && !restart && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || restart || (cnt_q == limit)) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

endmodule

// File: rtl/qser_queue.sv
module qser_queue #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [DW-1:0]            push_data,
  input  logic                     pop,
  output logic [DW-1:0]            head,
  output logic [$clog2(DEPTH)-1:0] rd_ptr,
  output logic [$clog2(DEPTH):0]   count,
  output logic                     full,
  output logic [1:0]               half_empty
);
  localparam int unsigned AW   = $clog2(DEPTH);
  localparam int unsigned HALF = DEPTH / 2;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q;
  logic [AW-1:0] rd_q;
  logic [AW:0]   cnt_q;

  assign full   = (cnt_q == (AW+1)'(DEPTH));
  assign head   = mem[rd_q];
  assign rd_ptr = rd_q;
  assign count  = cnt_q;

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= wr_q + AW'(1);
      if (pop)  rd_q <= rd_q + AW'(1);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + (AW+1)'(1);
        2'b01:   cnt_q <= cnt_q - (AW+1)'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // One drained flag per half; the half is picked by the pointer MSB.
  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam logic [AW-1:0] LAST = AW'(h * HALF + HALF - 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        half_empty[h] <= 1'b1;
      end else if (push && (wr_q[AW-1] == 1'(h))) begin
        half_empty[h] <= 1'b0;
      end else if (pop && (rd_q == LAST)) begin
        half_empty[h] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/qser_frame.sv
module qser_frame
  import qser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              long_fr,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              txd,
  output logic              busy,
  output logic              stop_begin
);
  fr_state_t          st_q;
  logic [FRAME_W-1:0] sh_q;
  logic [3:0]         idx_q;
  logic [3:0]         len_q;

  assign busy       = (st_q == FR_SEND);
  assign txd        = busy ? sh_q[0] : 1'b1;
  assign stop_begin = busy && tick && (idx_q == (len_q - 4'd2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FR_IDLE;
      sh_q  <= '1;
      idx_q <= '0;
      len_q <= 4'd10;
    end else if (!busy) begin
      if (load) begin
        st_q  <= FR_SEND;
        sh_q  <= build_frame(word, long_fr, par_en, par_odd);
        idx_q <= '0;
        len_q <= long_fr ? 4'd11 : 4'd10;
      end
    end else if (tick) begin
      if (idx_q == (len_q - 4'd1)) begin
        st_q <= FR_IDLE;
      end else begin
        sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
        idx_q <= idx_q + 4'd1;
      end
    end
  end

endmodule

// File: rtl/qser_tx.sv
module qser_tx
  import qser_pkg::*;
#(
  parameter int unsigned DIV_W  = 13,
  parameter int unsigned QDEPTH = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DIV_W-1:0]          cfg_div,
  input  logic                      cfg_long,
  input  logic                      cfg_par_en,
  input  logic                      cfg_par_odd,
  input  logic                      cfg_queue_en,
  input  logic                      cfg_irq_bot_en,
  input  logic                      cfg_irq_top_en,
  input  logic                      wr_valid,
  output logic                      wr_ready,
  input  logic [8:0]                wr_data,
  output logic                      txd,
  output logic                      tx_empty,
  output logic [$clog2(QDEPTH)-1:0] q_ptr,
  output logic [$clog2(QDEPTH):0]   q_pending,
  output logic                      q_bot_empty,
  output logic                      q_top_empty,
  output logic                      q_overflow,
  output logic                      irq_bot,
  output logic                      irq_top
);
  logic [WORD_W-1:0] hold_q;
  logic              hold_full;
  logic              src_q;
  logic              ovf_q;
  logic              q_push, h_push, q_full, q_pop;
  logic              avail, start, busy, stop_begin, tick;
  logic [WORD_W-1:0] q_head, word;
  logic [1:0]        half_empty;

  assign q_push   = cfg_queue_en && wr_valid && !q_full;
  assign h_push   = !cfg_queue_en && wr_valid && !hold_full;
  assign wr_ready = cfg_queue_en ? !q_full : !hold_full;
  assign avail    = cfg_queue_en ? (q_pending != '0) : hold_full;
  assign start    = !busy && avail && (cfg_div != '0);
  assign word     = cfg_queue_en ? q_head : hold_q;
  assign q_pop    = stop_begin && src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      src_q     <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      if (h_push) begin
        hold_q    <= wr_data;
        hold_full <= 1'b1;
      end else if (start && !cfg_queue_en) begin
        hold_full <= 1'b0;
      end
      if (start) src_q <= cfg_queue_en;
      if (!cfg_queue_en)           ovf_q <= 1'b0;
      else if (wr_valid && q_full) ovf_q <= 1'b1;
    end
  end

  qser_baud #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .div     (cfg_div),
    .restart (start),
    .tick    (tick)
  );

  qser_queue #(.DEPTH(QDEPTH), .DW(WORD_W)) u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (q_push),
    .push_data  (wr_data),
    .pop        (q_pop),
    .head       (q_head),
    .rd_ptr     (q_ptr),
    .count      (q_pending),
    .full       (q_full),
    .half_empty (half_empty)
  );

  qser_frame u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .load       (start),
    .word       (word),
    .long_fr    (cfg_long),
    .par_en     (cfg_par_en),
    .par_odd    (cfg_par_odd),
    .txd        (txd),
    .busy       (busy),
    .stop_begin (stop_begin)
  );

  assign tx_empty    = !hold_full;
  assign q_bot_empty = half_empty[0];
  assign q_top_empty = half_empty[1];
  assign q_overflow  = ovf_q;
  assign irq_bot     = half_empty[0] && cfg_irq_bot_en;
  assign irq_top     = half_empty[1] && cfg_irq_top_en;

endmodule

// File: rtl/qser_tx_chk.sv
module qser_tx_chk #(
  parameter int unsigned QDEPTH = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cfg_queue_en,
  input logic                      wr_valid,
  input logic                      wr_ready,
  input logic                      tx_empty,
  input logic [$clog2(QDEPTH)-1:0] q_ptr,
  input logic [$clog2(QDEPTH):0]   q_pending,
  input logic                      q_overflow
);
  localparam int unsigned AW = $clog2(QDEPTH);
  localparam logic [AW:0] FULLV = (AW+1)'(QDEPTH);

  logic [AW-1:0] ptr_nx;
  logic [AW:0]   pend_up;
  logic [AW:0]   pend_dn;
  assign ptr_nx  = q_ptr + AW'(1);
  assign pend_up = q_pending + (AW+1)'(1);
  assign pend_dn = q_pending - (AW+1)'(1);

  p_single_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_queue_en && wr_valid && wr_ready |=> !tx_empty);

  p_full_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_queue_en && (q_pending == FULLV) |-> !wr_ready);

  p_pending_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($stable(q_pending) || (q_pending == $past(pend_up)) ||
              (q_pending == $past(pend_dn))));

  p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($stable(q_ptr) || (q_ptr == $past(ptr_nx))));

  p_drop_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_queue_en && wr_valid && (q_pending == FULLV) |=> q_overflow);

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_queue_en && q_overflow |=> q_overflow);

endmodule

bind qser_tx qser_tx_chk #(.QDEPTH(QDEPTH)) u_chk (.*);

// File: tb/qser_tx_tb.sv
module qser_tx_tb;
  localparam int DIV_W  = 4;
  localparam int QDEPTH = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DIV_W-1:0] cfg_div = '0;
  logic cfg_long = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_queue_en = 0;
  logic cfg_irq_bot_en = 0, cfg_irq_top_en = 0;
  logic       wr_valid = 0;
  logic       wr_ready;
  logic [8:0] wr_data = '0;
  logic       txd, tx_empty, q_bot_empty, q_top_empty, q_overflow;
  logic       irq_bot, irq_top;
  logic [3:0] q_ptr;
  logic [4:0] q_pending;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  qser_tx #(.DIV_W(DIV_W), .QDEPTH(QDEPTH)) u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int flen(input bit lng);
    return lng ? 11 : 10;
  endfunction

  // Expected frame from the requirements alone.
  function automatic logic [10:0] model(input logic [8:0] w, input bit lng,
                                        input bit pe, input bit odd);
    logic [10:0] f;
    int nd, ones;
    f = '1; f[0] = 1'b0; ones = 0;
    nd = (lng ? 9 : 8) - (pe ? 1 : 0);
    for (int i = 0; i < nd; i++) begin
      f[1+i] = w[i];
      ones += int'(w[i]);
    end
    if (pe) f[1+nd] = odd ? ~ones[0] : ones[0];
    return f;
  endfunction

  task automatic push(input logic [8:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rx_frame(input int len, input int per, output logic [10:0] bits,
                          output bit ok);
    int w;
    bits = '1; ok = 0; w = 0;
    @(negedge clk);
    while (txd !== 1'b0 && w < 20000) begin @(negedge clk); w++; end
    if (txd !== 1'b0) return;
    ok = 1;
    repeat (per / 2) @(negedge clk);
    bits[0] = txd;
    for (int i = 1; i < len; i++) begin
      repeat (per) @(negedge clk);
      bits[i] = txd;
    end
  endtask

  task automatic send_check(input logic [8:0] w, input string req);
    logic [10:0] got, exp, msk;
    bit ok;
    int len;
    len = flen(cfg_long);
    msk = 11'((1 << len) - 1);
    exp = model(w, cfg_long, cfg_par_en, cfg_par_odd) & msk;
    rx_frame(len, 32 * int'(cfg_div), got, ok);
    check(ok, {req, " frame seen"}, int'(ok), 1);
    check((got & msk) == exp, req, int'(got & msk), int'(exp));
  endtask

  task automatic line_high(input int n, input string req);
    bit hi = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) hi = 0;
    end
    check(hi, req, int'(hi), 1);
  endtask

  task automatic t_reset;
    check(txd === 1'b1, "R11 txd", int'(txd), 1);
    check(tx_empty === 1'b1, "R11 tx_empty", int'(tx_empty), 1);
    check(q_pending == 0, "R11 pending", int'(q_pending), 0);
    check(q_ptr == 0, "R11 ptr", int'(q_ptr), 0);
    check(q_overflow === 1'b0, "R11 overflow", int'(q_overflow), 0);
    check(q_bot_empty && q_top_empty, "R8 flags after reset",
          int'({q_top_empty, q_bot_empty}), 3);
  endtask

  task automatic t_baud;
    int cnt;
    cfg_div = 0;
    push(9'h0B3);
    check(tx_empty === 1'b0, "R4 tx_empty cleared", int'(tx_empty), 0);
    line_high(150, "R1 div zero keeps line high");
    for (int d = 2; d >= 1; d--) begin
      @(negedge clk);
      cfg_div = DIV_W'(d);
      cnt = 0;
      while (txd !== 1'b0 && cnt < 1000) begin @(negedge clk); cnt++; end
      cnt = 0;
      while (txd === 1'b0 && cnt < 1000) begin cnt++; @(negedge clk); end
      check(cnt == 32 * d, "R1 bit period", cnt, 32 * d);
      repeat (11 * 32 * d) @(negedge clk);
      if (d == 2) begin
        cfg_div = 0;
        push(9'h0C1);
      end
    end
  endtask

  task automatic t_single;
    cfg_div = 1; cfg_long = 0; cfg_par_en = 0;
    push(9'h05A);
    check(wr_ready === 1'b0, "R4 ready follows empty", int'(wr_ready), 0);
    fork
      send_check(9'h05A, "R2 short frame");
      begin
        @(negedge clk);
        check(tx_empty === 1'b1, "R4 empty at start bit", int'(tx_empty), 1);
      end
    join
    repeat (40) @(negedge clk);
    cfg_long = 1;
    push(9'h155);
    send_check(9'h155, "R2 long frame 9 data bits");
    repeat (40) @(negedge clk);
  endtask

  task automatic t_parity;
    cfg_div = 1;
    cfg_long = 1; cfg_par_en = 1; cfg_par_odd = 0;
    push(9'h0C3);
    send_check(9'h0C3, "R3 long even parity");
    repeat (40) @(negedge clk);
    cfg_long = 0; cfg_par_odd = 1;
    push(9'h052);
    send_check(9'h052, "R3 short odd parity");
    repeat (40) @(negedge clk);
    cfg_par_odd = 0;
    push(9'h007);
    send_check(9'h007, "R3 short even parity");
    repeat (40) @(negedge clk);
    cfg_par_en = 0;
  endtask

  task automatic t_queue;
    logic [8:0] w [16];
    @(negedge clk);
    cfg_div = 0; cfg_long = 0; cfg_par_en = 0;
    cfg_queue_en = 1; cfg_irq_bot_en = 1; cfg_irq_top_en = 1;
    @(negedge clk);
    check(irq_bot && irq_top, "R9 irq from empty flags",
          int'({irq_top, irq_bot}), 3);
    for (int i = 0; i < 16; i++) begin
      w[i] = 9'((i * 37 + 5) & 255);
      push(w[i]);
    end
    check(q_pending == 16, "R6 pending after 16 writes", int'(q_pending), 16);
    check(wr_ready === 1'b0, "R5 not ready when full", int'(wr_ready), 0);
    check(!q_bot_empty && !q_top_empty, "R8 flags clear on writes",
          int'({q_top_empty, q_bot_empty}), 0);
    check(!irq_bot && !irq_top, "R9 irq low", int'({irq_top, irq_bot}), 0);
    push(9'h1AA);
    check(q_overflow === 1'b1, "R10 overflow set", int'(q_overflow), 1);
    check(q_pending == 16, "R10 pending unchanged", int'(q_pending), 16);
    @(negedge clk);
    cfg_div = 1;
    for (int k = 1; k <= 16; k++) begin
      send_check(w[k-1], "R5 queued order");
      check(q_pending == 16 - k, "R6 pending count", int'(q_pending), 16 - k);
      check(q_ptr == 4'(k), "R7 pointer", int'(q_ptr), k & 15);
      check(q_bot_empty == (k >= 8), "R8 low half flag", int'(q_bot_empty),
            int'(k >= 8));
      check(q_top_empty == (k == 16), "R8 high half flag", int'(q_top_empty),
            int'(k == 16));
      check(irq_bot == (k >= 8), "R9 irq_bot", int'(irq_bot), int'(k >= 8));
    end
    check(q_overflow === 1'b1, "R10 overflow sticky", int'(q_overflow), 1);
    line_high(400, "R6 line high when drained");
    cfg_irq_bot_en = 0;
    #1;
    check(irq_bot === 1'b0, "R9 irq_bot masked", int'(irq_bot), 0);
    cfg_queue_en = 0;
    @(negedge clk);
    check(q_overflow === 1'b0, "R10 overflow cleared", int'(q_overflow), 0);
  endtask

  task automatic t_partial;
    logic [8:0] w [3];
    @(negedge clk);
    cfg_div = 0; cfg_queue_en = 1; cfg_long = 1; cfg_par_en = 1; cfg_par_odd = 0;
    for (int i = 0; i < 3; i++) begin
      w[i] = 9'(8'hE1 - i * 9);
      push(w[i]);
    end
    check(!q_bot_empty && q_top_empty, "R8 only low half written",
          int'({q_top_empty, q_bot_empty}), 2);
    @(negedge clk);
    cfg_div = 1;
    for (int k = 0; k < 3; k++) send_check(w[k], "R5 partial burst parity");
    check(q_pending == 0, "R6 pending zero", int'(q_pending), 0);
    check(q_ptr == 3, "R7 pointer after wrap", int'(q_ptr), 3);
    check(q_bot_empty === 1'b0, "R8 low half not drained", int'(q_bot_empty), 0);
    line_high(400, "R6 stop at zero");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_baud();
    t_single();
    t_parity();
    t_queue();
    t_partial();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule